// File: doc/BRIEF.md
# Fractional Clock-Enable Divider Bank

This block turns one fast source tick stream into several slower clock-enable outputs. Four outputs divide by fixed integer ratios. One output divides by a ratio picked from a two-bit select input, and that ratio may be integer or fractional. One more output divides by the fractional ratio 100/19. Each output is a single-cycle pulse, issued once per output period. The whole block runs on one system clock, and an input tick says when the chosen source has an edge.

A fractional ratio N/D comes from mixing two integer periods, floor(N/D) and floor(N/D)+1. A remainder accumulator decides which of the two comes next, and the mix repeats exactly every D output periods. A bypass input makes every divider count reference ticks in place of source ticks. A synchronous clear input restarts all dividers in phase. A common enable forces every output low while the dividers go on counting. A pass-through output repeats each reference tick, gated by the same enable.

Top module: `clkdiv_bank`

## Requirements
- R1: Each fixed output pulses once every 28, 14, 8 and 2 counted ticks, on en_fixed bits 0, 1, 2 and 3 in that order.
- R2: With ratio_sel = 01, en_sel pulses every 7 counted ticks.
- R3: With ratio_sel = 10, the en_sel periods repeat the pattern 6, 6, 5, 6, 5 ticks, which is 28 ticks for every 5 pulses.
- R4: With ratio_sel = 11 or 00, the en_sel periods alternate 11 and 10 ticks, starting with 11. The codes 00 and 11 count as the same mode.
- R5: The en_frac periods repeat a 19-period pattern covering 100 ticks. The periods at positions 0, 3, 7, 11 and 15 last 6 ticks and all the others last 5.
- R6: A change of ratio_sel takes effect only when the current en_sel period ends. The next period is then the first period of the new mode's pattern.
- R7: When bypass is 1, every divider counts ref_tick and ignores src_tick. When bypass is 0, it counts src_tick.
- R8: When out_en is 0, every divided output and en_ref are 0 in the next cycle. The dividers keep counting, so the pulse phase is unchanged when out_en returns to 1.
- R9: A cycle with div_clr = 1 forces all outputs to 0 in the next cycle. Every divider then pulses on the first counted tick after the clear.
- R10: en_ref equals ref_tick AND out_en, one cycle later.
- R11: During reset all outputs are 0. After reset every divider pulses on the first counted tick, and the select divider starts in the mode given by ratio_sel on that tick.
- R12: A divided output pulses only in the cycle after a counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 1 | One-cycle tick from the fast source |
| ref_tick | input | 1 | One-cycle tick from the reference |
| bypass | input | 1 | 1: dividers count ref_tick; 0: dividers count src_tick |
| div_clr | input | 1 | Synchronous clear that realigns all dividers |
| out_en | input | 1 | Common output enable |
| ratio_sel | input | 2 | Ratio select for en_sel |
| en_fixed | output | 4 | Fixed-ratio pulses: bit0 /28, bit1 /14, bit2 /8, bit3 /2 |
| en_sel | output | 1 | Selectable-ratio pulse |
| en_frac | output | 1 | Pulse at 100/19 of the tick rate |
| en_ref | output | 1 | Gated pass-through of ref_tick |

## Verification
A corrupted remainder accumulator does not change the average rate right away. It shows up as a single period of the wrong length, for example a 5 where a 6 was due, inside the first repeat of the pattern, which is at most 19 periods long. For that reason the bench checks the length of every period, and not only the average. A down-counter that loads a wrong value moves the next pulse at once. A mode latch that updates in mid-period produces a short period before the boundary, so the first period after a select change carries its own check. Gating or clear faults show up as a pulse in the cycle just after the stimulus.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Shared widths, select modes and ratio decoding for the divider bank.
// Assumes every ratio N/D satisfies D <= 2**FR_W-1 and N/D < 2**CNT_W.
package clkdiv_pkg;
    localparam int CNT_W = 6;
    localparam int FR_W  = 5;

    typedef struct packed {
        logic [CNT_W-1:0] q;    // integer part of N/D
        logic [FR_W-1:0]  rem;  // N mod D
        logic [FR_W-1:0]  den;  // D
    } ratio_t;

    typedef enum logic [1:0] {
        MODE_DIV7   = 2'b01,
        MODE_DIV5P6 = 2'b10,
        MODE_DIV10P5 = 2'b11
    } sel_mode_e;

    // Fold the unused code 00 onto the default mode.
    function automatic sel_mode_e canon_mode(input logic [1:0] s);
        case (s)
            2'b01:   return MODE_DIV7;
            2'b10:   return MODE_DIV5P6;
            default: return MODE_DIV10P5;
        endcase
    endfunction

    // Ratio for each select mode: 7/1, 28/5, 21/2.
    function automatic ratio_t mode_ratio(input sel_mode_e m);
        ratio_t r;
        case (m)
            MODE_DIV7:   r = '{q: CNT_W'(7),  rem: FR_W'(0), den: FR_W'(1)};
            MODE_DIV5P6: r = '{q: CNT_W'(5),  rem: FR_W'(3), den: FR_W'(5)};
            default:     r = '{q: CNT_W'(10), rem: FR_W'(1), den: FR_W'(2)};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/tick_source.sv
`timescale 1ns/1ps
// Picks the tick stream that the dividers count, and registers the gated
// reference pass-through. Assumes both tick inputs are synchronous to clk.
module tick_source (
    input  logic clk,
    input  logic rst_n,
    input  logic src_tick,
    input  logic ref_tick,
    input  logic bypass,
    input  logic out_en,
    output logic cnt_tick,
    output logic ref_pass
);
    // Source swap: the reference drives the dividers while bypass is set.
    always_comb begin
        cnt_tick = bypass ? ref_tick : src_tick;
    end

    // Pass-through register, gated by the common enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pass <= 1'b0;
        end else begin
            ref_pass <= ref_tick & out_en;
        end
    end
endmodule

// File: rtl/frac_div.sv
`timescale 1ns/1ps
// Dual-modulus divider. The ratio q + rem/den is made by mixing periods of
// q and q+1 ticks through a remainder accumulator. New ratio inputs are
// taken only when a period ends. A change of mode code, or a fresh start,
// reloads the accumulator with den-1, which gives the long period first.
// Assumes rem < den, den >= 1, q >= 2.
module frac_div #(
    parameter int CNT_W = 6,
    parameter int FR_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             out_en,
    input  logic [1:0]       code,
    input  logic [CNT_W-1:0] q,
    input  logic [FR_W-1:0]  rem,
    input  logic [FR_W-1:0]  den,
    output logic             pulse
);
    localparam int SUM_W = FR_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [FR_W-1:0]  r_acc;
    logic [1:0]       cur_code;
    logic             fresh;

    logic             boundary;
    logic [FR_W-1:0]  r_base;
    logic [SUM_W-1:0] r_sum;
    logic             long_per;
    logic [CNT_W-1:0] load_val;
    logic [FR_W-1:0]  r_next;

    // Next-period choice: long when the remainder wraps past den.
    always_comb begin
        boundary = tick && (cnt == '0);
        r_base   = (fresh || (code != cur_code)) ? den - FR_W'(1) : r_acc;
        r_sum    = SUM_W'(r_base) + SUM_W'(rem);
        long_per = (r_sum >= SUM_W'(den));
        load_val = long_per ? q : q - CNT_W'(1);
        r_next   = long_per ? FR_W'(r_sum - SUM_W'(den)) : FR_W'(r_sum);
    end

    // Down-counter, accumulator and gated pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            r_acc    <= '0;
            cur_code <= 2'b11;
            fresh    <= 1'b1;
            pulse    <= 1'b0;
        end else begin
            pulse <= boundary & out_en;
            if (tick) begin
                if (cnt == '0) begin
                    cnt      <= load_val;
                    r_acc    <= r_next;
                    cur_code <= code;
                    fresh    <= 1'b0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
// Divider bank: four fixed integer dividers, one selectable divider and one
// 100/19 divider, all counting the same tick and realigned by div_clr.
// Assumes ratio_sel and all ticks are synchronous to clk.
module clkdiv_bank #(
    parameter int DIV_F0   = 28,
    parameter int DIV_F1   = 14,
    parameter int DIV_F2   = 8,
    parameter int DIV_F3   = 2,
    parameter int FRAC_NUM = 100,
    parameter int FRAC_DEN = 19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_tick,
    input  logic       ref_tick,
    input  logic       bypass,
    input  logic       div_clr,
    input  logic       out_en,
    input  logic [1:0] ratio_sel,
    output logic [3:0] en_fixed,
    output logic       en_sel,
    output logic       en_frac,
    output logic       en_ref
);
    import clkdiv_pkg::*;

    localparam int NUM_FIX  = 4;
    localparam int FIX_TAB [NUM_FIX] = '{DIV_F0, DIV_F1, DIV_F2, DIV_F3};
    localparam int FRAC_Q   = FRAC_NUM / FRAC_DEN;
    localparam int FRAC_REM = FRAC_NUM % FRAC_DEN;

    logic      cnt_tick;
    sel_mode_e sel_mode;
    ratio_t    sel_ratio;

    // Decode the select pins into a mode and its ratio.
    always_comb begin
        sel_mode  = canon_mode(ratio_sel);
        sel_ratio = mode_ratio(sel_mode);
    end

    tick_source u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .ref_tick (ref_tick),
        .bypass   (bypass),
        .out_en   (out_en),
        .cnt_tick (cnt_tick),
        .ref_pass (en_ref)
    );

    for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
        frac_div #(.CNT_W(CNT_W), .FR_W(FR_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (div_clr),
            .tick   (cnt_tick),
            .out_en (out_en),
            .code   (2'b00),
            .q      (CNT_W'(FIX_TAB[g])),
            .rem    (FR_W'(0)),
            .den    (FR_W'(1)),
            .pulse  (en_fixed[g])
        );
    end

    frac_div #(.CNT_W(CNT_W), .FR_W(FR_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (div_clr),
        .tick   (cnt_tick),
        .out_en (out_en),
        .code   (sel_mode),
        .q      (sel_ratio.q),
        .rem    (sel_ratio.rem),
        .den    (sel_ratio.den),
        .pulse  (en_sel)
    );

    frac_div #(.CNT_W(CNT_W), .FR_W(FR_W)) u_frac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (div_clr),
        .tick   (cnt_tick),
        .out_en (out_en),
        .code   (2'b00),
        .q      (CNT_W'(FRAC_Q)),
        .rem    (FR_W'(FRAC_REM)),
        .den    (FR_W'(FRAC_DEN)),
        .pulse  (en_frac)
    );
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
// Port-level properties of the divider bank, bound to every instance.
module clkdiv_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       src_tick,
    input logic       ref_tick,
    input logic       bypass,
    input logic       div_clr,
    input logic       out_en,
    input logic [3:0] en_fixed,
    input logic       en_sel,
    input logic       en_frac,
    input logic       en_ref
);
    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (en_fixed == 4'b0 && !en_sel && !en_frac && !en_ref));

    a_r12_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !(bypass ? ref_tick : src_tick) |=> (en_fixed == 4'b0 && !en_sel && !en_frac));

    a_r9_clear_silences: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr |=> (en_fixed == 4'b0 && !en_sel && !en_frac));

    a_r1_div28_on_div14: assert property (@(posedge clk) disable iff (!rst_n)
        en_fixed[0] |-> en_fixed[1]);

    a_r1_div14_on_div2: assert property (@(posedge clk) disable iff (!rst_n)
        en_fixed[1] |-> en_fixed[3]);

    a_r10_ref_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        en_ref |-> $past(ref_tick && out_en));

    a_r2_sel_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        en_sel |=> !en_sel);
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .ref_tick (ref_tick),
    .bypass   (bypass),
    .div_clr  (div_clr),
    .out_en   (out_en),
    .en_fixed (en_fixed),
    .en_sel   (en_sel),
    .en_frac  (en_frac),
    .en_ref   (en_ref)
);

// File: tb/clkdiv_bank_bench.sv
`timescale 1ns/1ps
// Bench: directed phases, then seeded random ticks, bypass, select, enable
// and clear. Each output period is measured in counted ticks and compared
// against the pattern from the requirements.
module clkdiv_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n, src_tick, ref_tick, bypass, div_clr, out_en;
    logic [1:0] ratio_sel;
    logic [3:0] en_fixed;
    logic       en_sel, en_frac, en_ref;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    int    since   [6];
    int    kidx    [6];
    bit    started [6];
    int    sel_mode;
    bit    sel_chg;
    string first_tag;

    always #2.5 clk = ~clk;

    clkdiv_bank u_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ref_tick(ref_tick),
        .bypass(bypass), .div_clr(div_clr), .out_en(out_en),
        .ratio_sel(ratio_sel), .en_fixed(en_fixed), .en_sel(en_sel),
        .en_frac(en_frac), .en_ref(en_ref)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int canon(input logic [1:0] s);
        if (s == 2'b01) return 1;
        if (s == 2'b10) return 2;
        return 3;
    endfunction

    // Period length in ticks, from the requirement patterns.
    function automatic int explen(input int i, input int m, input int k);
        int p;
        case (i)
            0: return 28;
            1: return 14;
            2: return 8;
            3: return 2;
            5: begin
                p = k % 19;
                return (p == 0 || p == 3 || p == 7 || p == 11 || p == 15) ? 6 : 5;
            end
            default: begin
                if (m == 1) return 7;
                if (m == 2) return ((k % 5) == 2 || (k % 5) == 4) ? 5 : 6;
                return ((k % 2) == 0) ? 11 : 10;
            end
        endcase
    endfunction

    function automatic string tag_of(input int i, input int m);
        if (i < 4) return "R1";
        if (i == 5) return "R5";
        if (m == 1) return "R2";
        if (m == 2) return "R3";
        return "R4";
    endfunction

    task automatic track(input int i, input bit vis, input bit got, input bit byp);
        int    e;
        string t;
        if (!started[i]) begin
            if (vis) chk(got == 1'b1, first_tag, $sformatf("first pulse out%0d", i), got, 1);
            started[i] = 1'b1;
            since[i]   = 0;
            kidx[i]    = 0;
            if (i == 4) begin
                sel_mode = canon(ratio_sel);
                sel_chg  = 1'b0;
            end
            return;
        end
        since[i]++;
        e = explen(i, sel_mode, kidx[i]);
        t = byp ? "R7" : ((i == 4 && sel_chg) ? "R6" : tag_of(i, sel_mode));
        if (since[i] >= e) begin
            if (vis) chk(got == 1'b1, t, $sformatf("period end out%0d len %0d", i, e), got, 1);
            since[i] = 0;
            kidx[i]++;
            if (i == 4) begin
                sel_chg = 1'b0;
                if (canon(ratio_sel) != sel_mode) begin
                    sel_mode = canon(ratio_sel);
                    kidx[i]  = 0;
                    sel_chg  = 1'b1;
                end
            end
        end else if (vis) begin
            chk(got == 1'b0, t, $sformatf("mid period out%0d at %0d of %0d", i, since[i], e), got, 0);
        end
    endtask

    task automatic observe();
        logic [5:0] o;
        bit         tk;
        o  = {en_frac, en_sel, en_fixed};
        tk = div_clr ? 1'b0 : (bypass ? ref_tick : src_tick);
        chk(en_ref == (ref_tick & out_en), "R10", "reference pass", en_ref, ref_tick & out_en);
        if (div_clr) begin
            for (int i = 0; i < 6; i++) begin
                chk(o[i] == 1'b0, "R9", $sformatf("clear out%0d", i), o[i], 0);
                started[i] = 1'b0;
            end
            first_tag = "R9";
            return;
        end
        for (int i = 0; i < 6; i++) begin
            if (!tk) begin
                chk(o[i] == 1'b0, "R12", $sformatf("no tick out%0d", i), o[i], 0);
            end else if (!out_en) begin
                chk(o[i] == 1'b0, "R8", $sformatf("gated out%0d", i), o[i], 0);
                track(i, 1'b0, 1'b0, bypass);
            end else begin
                track(i, 1'b1, o[i], bypass);
            end
        end
    endtask

    // One cycle: drive after the falling edge, sample at the next falling edge.
    task automatic cyc(input bit s, input bit r, input bit b, input bit oe,
                       input logic [1:0] sel, input bit c);
        src_tick = s; ref_tick = r; bypass = b; out_en = oe;
        ratio_sel = sel; div_clr = c;
        @(negedge clk);
        if (rst_n) begin
            observe();
        end else begin
            chk({en_fixed, en_sel, en_frac, en_ref} == 7'b0, "R11", "reset state",
                {en_fixed, en_sel, en_frac, en_ref}, 0);
        end
    endtask

    initial begin
        int         seg_byp;
        int         oe_low;
        logic [1:0] rsel;
        void'($urandom(32'd1234));
        rst_n = 1'b0; first_tag = "R11";
        for (int i = 0; i < 6; i++) started[i] = 1'b0;
        src_tick = 0; ref_tick = 0; bypass = 0; div_clr = 0; out_en = 1; ratio_sel = 2'b11;
        @(negedge clk);
        repeat (4) cyc(1, 1, 0, 1, 2'b11, 0);
        rst_n = 1'b1;
        // Directed: default mode, then each select code.
        repeat (240) cyc(1, 0, 0, 1, 2'b11, 0);
        repeat (90)  cyc(1, 0, 0, 1, 2'b01, 0);
        repeat (150) cyc(1, 0, 0, 1, 2'b10, 0);
        repeat (100) cyc(1, 0, 0, 1, 2'b00, 0);
        // Clear, then realignment from zero.
        cyc(0, 0, 0, 1, 2'b10, 1);
        repeat (120) cyc(1, 0, 0, 1, 2'b10, 0);
        // Enable low with ticks still counted.
        repeat (37)  cyc($urandom % 2, 0, 0, 0, 2'b10, 0);
        repeat (150) cyc(1, 0, 0, 1, 2'b10, 0);
        // Bypass: dividers follow the reference, source toggles randomly.
        for (int n = 0; n < 300; n++) cyc($urandom % 2, (n % 3) == 0, 1, 1, 2'b11, 0);
        // Random mix.
        seg_byp = 0; oe_low = 0; rsel = 2'b11;
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) seg_byp = $urandom % 2;
            if ($urandom % 60 == 0) rsel = 2'($urandom % 4);
            if (oe_low > 0) oe_low--;
            else if ($urandom % 200 == 0) oe_low = 5 + $urandom % 30;
            if ($urandom % 700 == 0)
                cyc(0, 0, seg_byp[0], oe_low == 0, rsel, 1);
            else
                cyc(($urandom % 4) != 0, ($urandom % 3) == 0, seg_byp[0], oe_low == 0, rsel, 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule